// File: doc/BRIEF.md
# SPI Controller Register Front End

This block is the bus-facing register file of a serial peripheral controller. It decodes a small 5-bit byte-address window into seven 16-bit registers: control, chip-select flags, status, transmit buffer, receive buffer, clock divisor and receive shadow. It applies reset values and accepts only halfword accesses. A rejected access gets an error response with a reason code and changes nothing. The serial shifter, the clock generator and any DMA path sit outside this block. The shifter reports events through a set-vector input, and the block publishes the live status word on an output port.

Each access is a one-cycle strobe, with `bus_wr` or `bus_rd` high and `bus_addr`, `bus_size` and `bus_wdata` valid. If both strobes are high, the write is performed and the read is dropped. The response comes one cycle later from a three-state response machine. RSP_IDLE means no response. RSP_DONE raises `bus_ack`, and read data appears on `bus_rdata` in the same cycle. RSP_FAULT raises `bus_err` and puts the reason on `bus_fault`. The machine enters RSP_DONE after an accepted access, RSP_FAULT after a rejected one, and RSP_IDLE in any cycle without a strobe.

Status flags also change as side effects of buffer accesses. Control bit 14 enables these side effects. Control bits [1:0] select the trigger mode: 00 fires on a receive-buffer read, 01 fires on a transmit-buffer write, and 10 and 11 fire on neither.

Top module: `spi_csr_block`

## Requirements
- R1: After reset, the registers read control 0x0400, flags 0xFF00 and status 0x0001. The transmit buffer, receive buffer, divisor and shadow all read 0x0000.
- R2: Control, flags, transmit buffer, receive buffer, divisor and shadow are plain storage. A write that is accepted is read back unchanged. Every accepted access raises `bus_ack` in the next cycle, and read data is valid in that same cycle.
- R3: The register offsets are control 0x00, flags 0x04, status 0x08, transmit buffer 0x0C, receive buffer 0x10, divisor 0x14 and shadow 0x18.
- R4: Only size code 01 (halfword) is legal. Codes 00 (byte), 10 (word) and 11 give `bus_err` with `bus_fault` = 1 in the next cycle. Such an access writes no register and causes no status side effect.
- R5: A halfword access to an offset that is not one of the seven registers gives `bus_err` with `bus_fault` = 2 and has no effect. This covers 0x1C to 0x1F and any offset that is not a multiple of 4. When the size is also illegal, code 1 is reported instead.
- R6: Bus writes cannot change status bits 0 (done), 3 (transmit-buffer full) or 5 (receive-buffer full).
- R7: Status bits 1 (mode fault), 2 (transmit empty), 4 (receive busy) and 6 (transmit collision) are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R8: When control bit 14 is 1 and the mode is 01, an accepted transmit-buffer write sets status bit 5 and clears status bit 3.
- R9: When control bit 14 is 1 and the mode is 00, an accepted receive-buffer read returns the buffer value and clears status bits 5 and 3.
- R10: A buffer access causes no status change when control bit 14 is 0 or when the mode does not match the access.
- R11: Bit i of `hw_set` sets status bit i at the next edge. A set takes priority over a bus clear or a side-effect clear of the same bit in the same cycle.
- R12: `status_word` carries the status register in bits [6:0] with bits [15:7] at zero. A status read returns the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe (wins over bus_rd) |
| bus_addr | input | 5 | Byte offset in the register window |
| bus_size | input | 2 | Access size code, 01 = halfword |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_ack after a read |
| bus_ack | output | 1 | Accepted-access response pulse |
| bus_err | output | 1 | Rejected-access response pulse |
| bus_fault | output | 2 | Reject reason: 1 size, 2 unmapped |
| hw_set | input | 7 | Status bit set requests from the shifter side |
| status_word | output | 16 | Live status register |

## Verification
The bench builds the block with the default parameters: a 5-bit window at a 4-byte stride holding seven registers. With these values, the unmapped offsets 0x1C to 0x1F and the misaligned offsets inside the window can all be reached. A single access can also carry both an illegal size and an unmapped offset, which exercises the priority between the two reasons. The default reset constants let the bench check every reset value. Because `hw_set` is driven in the same cycle as bus clears and trigger accesses, the set-over-clear priority can be tested in every trigger mode.

// File: rtl/spcsr_pkg.sv
package spcsr_pkg;

    // Register slots (offset = slot * 4)
    localparam int SLOT_CTL  = 0;
    localparam int SLOT_FLG  = 1;
    localparam int SLOT_STAT = 2;
    localparam int SLOT_TX   = 3;
    localparam int SLOT_RX   = 4;
    localparam int SLOT_DIV  = 5;
    localparam int SLOT_SHD  = 6;

    // Status bit positions
    localparam int ST_DONE  = 0;
    localparam int ST_MODF  = 1;
    localparam int ST_TXE   = 2;
    localparam int ST_TXF   = 3;
    localparam int ST_RBSY  = 4;
    localparam int ST_RXF   = 5;
    localparam int ST_TXCOL = 6;
    localparam int STAT_W   = 7;

    localparam logic [STAT_W-1:0] STAT_W1C_MASK = 7'b1010110;

    localparam int CTL_EN_BIT = 14;
    localparam logic [1:0] SIZE_HALF = 2'b01;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_SIZE     = 2'd1,
        FLT_UNMAPPED = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DONE  = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_e;

    typedef enum logic [1:0] {
        TRIG_ON_RX_READ  = 2'b00,
        TRIG_ON_TX_WRITE = 2'b01
    } trig_mode_e;

endpackage

// File: rtl/spcsr_decode.sv
module spcsr_decode
    import spcsr_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int NUM_REGS    = 7,
    parameter int STRIDE_LOG2 = 2,
    parameter int SLOT_W      = 3
) (
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              access,
    output logic              hit,
    output logic [SLOT_W-1:0] slot,
    output fault_e            fault
);
    localparam int IDX_W = ADDR_W - STRIDE_LOG2;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             in_range;

    always_comb begin
        access   = rd | wr;
        idx      = addr[ADDR_W-1:STRIDE_LOG2];
        aligned  = (addr[STRIDE_LOG2-1:0] == '0);
        in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_REGS));
        slot     = SLOT_W'(idx);
        if (!access)
            fault = FLT_NONE;
        else if (size != SIZE_HALF)
            fault = FLT_SIZE;          // size check outranks the map check
        else if (!(aligned && in_range))
            fault = FLT_UNMAPPED;
        else
            fault = FLT_NONE;
        hit = access && (fault == FLT_NONE);
    end
endmodule

// File: rtl/spcsr_status.sv
module spcsr_status
    import spcsr_pkg::*;
#(
    parameter logic [STAT_W-1:0] RESET_VAL = 7'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w1c_en,
    input  logic [STAT_W-1:0] w1c_data,
    input  logic              tx_trig,
    input  logic              rx_trig,
    input  logic [STAT_W-1:0] hw_set,
    output logic [STAT_W-1:0] stat_q
);
    logic [STAT_W-1:0] stat_nxt;

    always_comb begin
        stat_nxt = stat_q;
        if (w1c_en)
            stat_nxt = stat_nxt & ~(w1c_data & STAT_W1C_MASK);
        if (tx_trig) begin
            stat_nxt[ST_RXF] = 1'b1;
            stat_nxt[ST_TXF] = 1'b0;
        end
        if (rx_trig) begin
            stat_nxt[ST_RXF] = 1'b0;
            stat_nxt[ST_TXF] = 1'b0;
        end
        stat_nxt = stat_nxt | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= RESET_VAL;
        else        stat_q <= stat_nxt;
    end

    // R6: a bus write leaves the protected bits alone
    assert_protected_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_en && !tx_trig && !rx_trig && hw_set == '0) |=>
        (stat_q[ST_DONE] == $past(stat_q[ST_DONE]) &&
         stat_q[ST_TXF]  == $past(stat_q[ST_TXF]) &&
         stat_q[ST_RXF]  == $past(stat_q[ST_RXF])));

    // R7: a written 1 clears a clearable bit unless a set arrives
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_en && hw_set == '0) |=>
        ((stat_q & $past(w1c_data & STAT_W1C_MASK)) == '0));

    // R8: transmit trigger marks the receive buffer full and the transmit buffer free
    assert_tx_trigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_trig && !hw_set[ST_TXF]) |=> (stat_q[ST_RXF] && !stat_q[ST_TXF]));

    // R9: receive trigger drops both buffer flags
    assert_rx_trigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_trig && !hw_set[ST_TXF] && !hw_set[ST_RXF]) |=>
        (!stat_q[ST_RXF] && !stat_q[ST_TXF]));

    // R11: a requested set always lands
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((stat_q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/spi_csr_block.sv
module spi_csr_block
    import spcsr_pkg::*;
#(
    parameter int          ADDR_W      = 5,
    parameter int          DATA_W      = 16,
    parameter int          NUM_REGS    = 7,
    parameter int          STRIDE_LOG2 = 2,
    parameter logic [15:0] CTL_RST     = 16'h0400,
    parameter logic [15:0] FLG_RST     = 16'hFF00,
    parameter logic [15:0] STAT_RST    = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [1:0]        bus_fault,
    input  logic [STAT_W-1:0] hw_set,
    output logic [DATA_W-1:0] status_word
);
    localparam int SLOT_W = $clog2(NUM_REGS);

    function automatic logic [DATA_W-1:0] slot_rst(input int s);
        if (s == SLOT_CTL) return DATA_W'(CTL_RST);
        if (s == SLOT_FLG) return DATA_W'(FLG_RST);
        return '0;
    endfunction

    logic                             access;
    logic                             hit;
    logic [SLOT_W-1:0]                slot;
    fault_e                           fault;
    logic                             rd_eff;
    logic                             wr_hit;
    logic                             rd_hit;
    logic [NUM_REGS-1:0][DATA_W-1:0]  reg_q;
    logic [STAT_W-1:0]                stat_q;
    logic                             trig_en;
    logic [1:0]                       trig_mode;
    logic                             tx_trig;
    logic                             rx_trig;
    logic                             w1c_en;
    rsp_e                             rsp_q;
    rsp_e                             rsp_nxt;
    logic [DATA_W-1:0]                rdata_q;
    logic [DATA_W-1:0]                rdata_nxt;
    fault_e                           fault_q;

    assign rd_eff = bus_rd & ~bus_wr;

    spcsr_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
        .STRIDE_LOG2(STRIDE_LOG2), .SLOT_W(SLOT_W)
    ) i_decode (
        .rd(rd_eff), .wr(bus_wr), .addr(bus_addr), .size(bus_size),
        .access(access), .hit(hit), .slot(slot), .fault(fault)
    );

    assign wr_hit = hit & bus_wr;
    assign rd_hit = hit & rd_eff;

    // Plain storage, one flop group per slot; the status slot is a hole
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        if (i == SLOT_STAT) begin : g_hole
            assign reg_q[i] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= slot_rst(i);
                else if (wr_hit && slot == SLOT_W'(i))
                    q <= bus_wdata;
            end
            assign reg_q[i] = q;
        end
    end

    assign trig_en   = reg_q[SLOT_CTL][CTL_EN_BIT];
    assign trig_mode = reg_q[SLOT_CTL][1:0];
    assign tx_trig   = wr_hit && slot == SLOT_W'(SLOT_TX) && trig_en
                       && trig_mode == TRIG_ON_TX_WRITE;
    assign rx_trig   = rd_hit && slot == SLOT_W'(SLOT_RX) && trig_en
                       && trig_mode == TRIG_ON_RX_READ;
    assign w1c_en    = wr_hit && slot == SLOT_W'(SLOT_STAT);

    spcsr_status #(.RESET_VAL(STAT_RST[STAT_W-1:0])) i_status (
        .clk(clk), .rst_n(rst_n),
        .w1c_en(w1c_en), .w1c_data(bus_wdata[STAT_W-1:0]),
        .tx_trig(tx_trig), .rx_trig(rx_trig),
        .hw_set(hw_set), .stat_q(stat_q)
    );

    assign status_word = {{(DATA_W-STAT_W){1'b0}}, stat_q};

    // Response machine: next state
    always_comb begin
        rsp_nxt = RSP_IDLE;
        if (access) begin
            unique case (fault)
                FLT_NONE:     rsp_nxt = RSP_DONE;
                FLT_SIZE:     rsp_nxt = RSP_FAULT;
                FLT_UNMAPPED: rsp_nxt = RSP_FAULT;
                default:      rsp_nxt = RSP_FAULT;
            endcase
        end
    end

    always_comb begin
        rdata_nxt = '0;
        if (rd_hit)
            rdata_nxt = (slot == SLOT_W'(SLOT_STAT)) ? status_word : reg_q[slot];
    end

    // State register with its response payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q   <= RSP_IDLE;
            rdata_q <= '0;
            fault_q <= FLT_NONE;
        end else begin
            rsp_q   <= rsp_nxt;
            rdata_q <= rdata_nxt;
            fault_q <= fault;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        bus_ack   = 1'b0;
        bus_err   = 1'b0;
        bus_fault = FLT_NONE;
        unique case (rsp_q)
            RSP_IDLE:  ;
            RSP_DONE:  bus_ack = 1'b1;
            RSP_FAULT: begin
                bus_err   = 1'b1;
                bus_fault = fault_q;
            end
            default:   ;
        endcase
    end
    assign bus_rdata = rdata_q;

    // R2: an accepted strobe is acknowledged in the next cycle
    assert_ack_follows_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (bus_ack && !bus_err));

    // R4: an illegal size is answered with reason 1
    assert_size_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_size != SIZE_HALF) |=>
        (bus_err && bus_fault == 2'd1));

    // R5: a halfword beyond the last register is answered with reason 2
    assert_unmapped_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_size == SIZE_HALF &&
         {1'b0, bus_addr} >= (ADDR_W+1)'(NUM_REGS << STRIDE_LOG2)) |=>
        (bus_err && bus_fault == 2'd2));

    // R5: a rejected access leaves the control register and status untouched
    assert_reject_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !hit && hw_set == '0) |=>
        ($stable(reg_q[SLOT_CTL]) && $stable(status_word)));
endmodule

// File: tb/test_spi_csr_block.sv
`timescale 1ns/1ps
module test_spi_csr_block;

    typedef struct {
        logic        is_err;
        logic [1:0]  fault;
        logic        chk_data;
        logic [15:0] data;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'b01;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_ack;
    logic        bus_err;
    logic [1:0]  bus_fault;
    logic [6:0]  hw_set = '0;
    logic [15:0] status_word;

    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    spi_csr_block i_spi_csr_block (
        .clk(clk), .rst_n(rst_n),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .bus_fault(bus_fault), .hw_set(hw_set), .status_word(status_word)
    );

    // Monitor: pops one expected response per observed response
    always @(negedge clk) begin
        if (rst_n && (bus_ack || bus_err)) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL unexpected response: err=%0b fault=%0d data=%h expected none",
                         bus_err, bus_fault, bus_rdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (bus_err !== e.is_err || (e.is_err && bus_fault !== e.fault) ||
                    (e.chk_data && bus_rdata !== e.data)) begin
                    errors++;
                    $display("FAIL %s: err=%0b fault=%0d data=%h expected err=%0b fault=%0d data=%h",
                             e.req, bus_err, bus_fault, bus_rdata,
                             e.is_err, e.fault, e.data);
                end
            end
        end
    end

    // Driver: one strobe cycle, optional simultaneous hardware set
    task automatic access(input bit wr, input bit rd, input logic [4:0] a,
                          input logic [1:0] sz, input logic [15:0] wd,
                          input logic [6:0] hs, input exp_t e);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_size = sz;
        bus_wdata = wd; hw_set = hs;
        sb.push_back(e);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; hw_set = '0;
    endtask

    task automatic wr16(input logic [4:0] a, input logic [15:0] d, input string r);
        exp_t e = '{1'b0, 2'd0, 1'b0, 16'h0, r};
        access(1'b1, 1'b0, a, 2'b01, d, 7'h0, e);
    endtask

    task automatic rd16(input logic [4:0] a, input logic [15:0] x, input string r);
        exp_t e = '{1'b0, 2'd0, 1'b1, x, r};
        access(1'b0, 1'b1, a, 2'b01, 16'h0, 7'h0, e);
    endtask

    task automatic bad(input bit wr, input logic [4:0] a, input logic [1:0] sz,
                       input logic [15:0] d, input logic [1:0] code, input string r);
        exp_t e = '{1'b1, code, 1'b0, 16'h0, r};
        access(wr, !wr, a, sz, d, 7'h0, e);
    endtask

    task automatic pulse_set(input logic [6:0] v);
        @(negedge clk); hw_set = v;
        @(negedge clk); hw_set = '0;
    endtask

    task automatic chk_stat(input logic [15:0] x, input string r);
        checks++;
        if (status_word !== x) begin
            errors++;
            $display("FAIL %s: status_word=%h expected %h", r, status_word, x);
        end
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2 missing responses: pending=%0d expected 0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3 reset values at each offset
        chk_stat(16'h0001, "R1 status reset");
        rd16(5'h00, 16'h0400, "R1 R3 control reset");
        rd16(5'h04, 16'hFF00, "R1 R3 flags reset");
        rd16(5'h08, 16'h0001, "R1 R3 status reset");
        rd16(5'h0C, 16'h0000, "R1 R3 tx reset");
        rd16(5'h10, 16'h0000, "R1 R3 rx reset");
        rd16(5'h14, 16'h0000, "R1 R3 divisor reset");
        rd16(5'h18, 16'h0000, "R1 R3 shadow reset");

        // R2 plain storage (side effects disabled: control bit 14 = 0)
        wr16(5'h04, 16'h1234, "R2 flags write");
        wr16(5'h14, 16'h00A5, "R2 divisor write");
        wr16(5'h18, 16'hBEEF, "R2 shadow write");
        wr16(5'h10, 16'h5A5A, "R2 rx write");
        wr16(5'h0C, 16'hC3C3, "R2 tx write");
        rd16(5'h04, 16'h1234, "R2 flags readback");
        rd16(5'h14, 16'h00A5, "R2 divisor readback");
        rd16(5'h18, 16'hBEEF, "R2 shadow readback");
        rd16(5'h10, 16'h5A5A, "R2 rx readback");
        rd16(5'h0C, 16'hC3C3, "R2 tx readback");
        chk_stat(16'h0001, "R10 disabled tx write");

        // R4 illegal sizes
        bad(1'b0, 5'h00, 2'b00, 16'h0, 2'd1, "R4 byte read");
        bad(1'b1, 5'h04, 2'b10, 16'h0000, 2'd1, "R4 word write");
        bad(1'b1, 5'h04, 2'b11, 16'h0000, 2'd1, "R4 reserved size write");
        rd16(5'h04, 16'h1234, "R4 flags unchanged");
        // R5 priority: bad size plus unmapped offset reports size
        bad(1'b1, 5'h1C, 2'b00, 16'h0, 2'd1, "R5 size outranks map");

        // R5 unmapped offsets
        bad(1'b0, 5'h1C, 2'b01, 16'h0, 2'd2, "R5 offset 0x1C read");
        bad(1'b1, 5'h06, 2'b01, 16'h0000, 2'd2, "R5 misaligned write");
        bad(1'b1, 5'h1F, 2'b01, 16'h0000, 2'd2, "R5 offset 0x1F write");
        rd16(5'h04, 16'h1234, "R5 flags unchanged");

        // R11 hardware sets, R6 protected bits, R7 write-one-to-clear
        pulse_set(7'h7F);
        chk_stat(16'h007F, "R11 all bits set");
        wr16(5'h08, 16'h0029, "R6 write protected bits");
        chk_stat(16'h007F, "R6 protected bits hold");
        wr16(5'h08, 16'h0002, "R7 clear mode fault");
        chk_stat(16'h007D, "R7 single clear");
        bad(1'b1, 5'h08, 2'b00, 16'hFFFF, 2'd1, "R4 bad-size status write");
        chk_stat(16'h007D, "R4 status untouched");
        wr16(5'h08, 16'hFF80, "R7 upper-bit write");
        chk_stat(16'h007D, "R7 zeros keep bits");
        wr16(5'h08, 16'hFFFF, "R7 clear all");
        chk_stat(16'h0029, "R7 R6 clearable gone, protected kept");
        rd16(5'h08, 16'h0029, "R12 status read");

        // R9 receive trigger mode
        wr16(5'h00, 16'h4000, "R2 control rx mode");
        rd16(5'h10, 16'h5A5A, "R9 rx read value");
        chk_stat(16'h0001, "R9 flags cleared");
        wr16(5'h0C, 16'h7777, "R10 tx write in rx mode");
        chk_stat(16'h0001, "R10 wrong mode tx");

        // R8 transmit trigger mode
        pulse_set(7'h08);
        chk_stat(16'h0009, "R11 set tx full");
        wr16(5'h00, 16'h4001, "R2 control tx mode");
        rd16(5'h10, 16'h5A5A, "R10 rx read in tx mode");
        chk_stat(16'h0009, "R10 wrong mode rx");
        wr16(5'h0C, 16'h2222, "R8 tx write");
        chk_stat(16'h0021, "R8 rx full set, tx full cleared");
        rd16(5'h0C, 16'h2222, "R2 tx readback");

        // R10 disabled and unused modes
        wr16(5'h00, 16'h0001, "R2 control disabled");
        pulse_set(7'h08);
        wr16(5'h0C, 16'h3333, "R10 tx write disabled");
        chk_stat(16'h0029, "R10 disabled no change");
        wr16(5'h00, 16'h4002, "R2 control mode 10");
        wr16(5'h0C, 16'h4444, "R10 tx write mode 10");
        rd16(5'h10, 16'h5A5A, "R10 rx read mode 10");
        chk_stat(16'h0029, "R10 mode 10 no change");

        // R4 bad-size rx read in rx mode has no side effect
        wr16(5'h00, 16'h4000, "R2 control rx mode again");
        bad(1'b0, 5'h10, 2'b00, 16'h0, 2'd1, "R4 bad-size rx read");
        chk_stat(16'h0029, "R4 no side effect");

        // R11 set beats clears in the same cycle
        begin
            exp_t e = '{1'b0, 2'd0, 1'b1, 16'h5A5A, "R11 rx read with set"};
            access(1'b0, 1'b1, 5'h10, 2'b01, 16'h0, 7'h20, e);
        end
        chk_stat(16'h0021, "R11 rx full survives trigger");
        begin
            exp_t e = '{1'b0, 2'd0, 1'b0, 16'h0, "R11 w1c with set"};
            access(1'b1, 1'b0, 5'h08, 2'b01, 16'h0002, 7'h02, e);
        end
        chk_stat(16'h0023, "R11 mode fault survives w1c");
        rd16(5'h08, 16'h0023, "R12 status read matches port");

        finish_run();
    end
endmodule